// File: doc/BRIEF.md
# Watchdog Timer with Frequency Revert

This block guards a frequency change made by software. Software picks a timeout with a 4-bit code and then has to show it is still alive, either by raising a reload bit from 0 to 1 or by writing a new timeout code. If the time runs out first, the block sets a sticky alarm flag and drives a system reset output low for a fixed interval. It also reports which frequency setting the synthesizer must return to. That setting is either the strap value latched by hardware or the last setting written by software.

All timing comes from a reference clock. A prescaler divides it to a millisecond tick, and its ratio is a parameter, so a bench can run on a scaled-down timebase. The control bits come in as plain inputs from a register bank that lives outside the block.

Top module: `wdog_revert`

## Requirements
- R1: Timeout code 0 disables the watchdog. While it is applied no alarm is raised and no reset pulse appears, and a reload edge has no effect.
- R2: Code 1 selects a 10 ms timeout. The alarm becomes visible 10·TICKS_PER_MS reference cycles after the clock edge that sampled the start.
- R3: Code c from 2 to 15 selects 2·c seconds (4 s at code 2, 6 s at code 3, 30 s at code 15), counted in the same way.
- R4: A 0-to-1 change of `reload_bit` restarts the full timeout of the current code. Holding the bit high does not restart the count again.
- R5: Writing a different non-zero code while the timer runs restarts the count with the new length.
- R6: At expiry `alarm` goes to 1 and stays at 1 until code 0 is applied. It is 0 one cycle after code 0 is sampled.
- R7: At expiry `sys_rst_n` goes low in the same cycle that `alarm` rises, and stays low for 3 ms (3·TICKS_PER_MS cycles).
- R8: At expiry `revert_sw` takes the value of `recover_sel`: 0 means restore the hardware-latched straps, 1 means keep the software setting. Later changes of `recover_sel` do not change `revert_sw` until the next expiry.
- R9: While reset is applied, `alarm` is 0, `sys_rst_n` is 1 and `revert_sw` is 0.
- R10: After expiry the count stops. No second reset pulse appears unless a new start occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmo_code | input | 4 | Timeout code (0 = off) |
| reload_bit | input | 1 | Restart request, acts on a rising level |
| recover_sel | input | 1 | Setting to apply after expiry (0 = hardware straps, 1 = software) |
| alarm | output | 1 | Sticky expiry flag |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| revert_sw | output | 1 | Frequency source chosen at the last expiry |

## Verification
The bench predicts the exact cycle of every expiry, so a design that is off by a single tick, or that keeps its prescaler phase across a restart, reports a cycle miscompare. A reload that is held high, and a code change from 2 to 3 part-way through a count, catch designs that retrigger on a level or ignore a new code; these show up as an early, late or unexpected alarm. Reset pulses are measured for their width, and a second pulse with no alarm edge is flagged, which exposes a counter that keeps running after expiry. After each expiry the bench flips `recover_sel` and holds the alarm window open, which catches a revert output that follows its input live or an alarm that clears by itself.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef logic [3:0] tmo_code_t;

  localparam tmo_code_t TMO_OFF   = 4'd0;
  localparam tmo_code_t TMO_SHORT = 4'd1;

  // Timeout length in milliseconds for a code; 0 means disabled.
  function automatic int unsigned tmo_limit_ms(tmo_code_t c, int unsigned short_ms,
                                               int unsigned step_ms);
    if (c == TMO_OFF)   return 0;
    if (c == TMO_SHORT) return short_ms;
    return int'(c) * step_ms;
  endfunction
endpackage

// File: rtl/wdr_ms_tick.sv
module wdr_ms_tick #(
  parameter int unsigned TICKS_PER_MS = 14318
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic ms_tick
);
  localparam int unsigned PW = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_MS - 1);

  logic [PW-1:0] presc_q, presc_d;

  always_comb begin
    presc_d = presc_q;
    if (clr)
      presc_d = '0;
    else if (run)
      presc_d = (presc_q == LAST) ? '0 : presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else        presc_q <= presc_d;
  end

  assign ms_tick = run && !clr && (presc_q == LAST);
endmodule

// File: rtl/wdr_countdown.sv
module wdr_countdown
  import wdr_pkg::*;
#(
  parameter int unsigned SHORT_MS = 10,
  parameter int unsigned STEP_MS  = 2000,
  parameter int unsigned MS_W     = 15
) (
  input  logic      clk,
  input  logic      rst_n,
  input  tmo_code_t code,
  input  logic      reload_bit,
  input  logic      ms_tick,
  output logic      running,
  output logic      restart,
  output logic      expire
);
  tmo_code_t       code_q;
  logic            reload_q;
  logic [MS_W-1:0] left_q, left_d;
  logic            run_q, run_d;
  logic            enabled;

  assign enabled = (code != TMO_OFF);
  assign restart = enabled && ((reload_bit && !reload_q) || (code != code_q));
  assign expire  = enabled && !restart && run_q && ms_tick && (left_q == MS_W'(1));
  assign running = run_q;

  always_comb begin
    left_d = left_q;
    run_d  = run_q;
    if (!enabled) begin
      run_d = 1'b0;
    end else if (restart) begin
      left_d = MS_W'(tmo_limit_ms(code, SHORT_MS, STEP_MS));
      run_d  = 1'b1;
    end else if (run_q && ms_tick) begin
      left_d = left_q - 1'b1;
      if (left_q == MS_W'(1)) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= TMO_OFF;
      reload_q <= 1'b0;
      left_q   <= '0;
      run_q    <= 1'b0;
    end else begin
      code_q   <= code;
      reload_q <= reload_bit;
      left_q   <= left_d;
      run_q    <= run_d;
    end
  end

  // R1
  off_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == TMO_OFF) |=> !run_q);
  // R10
  halt_after_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !run_q);
endmodule

// File: rtl/wdr_rst_pulse.sv
module wdr_rst_pulse #(
  parameter int unsigned PULSE_CYC = 42954
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic sys_rst_n
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (fire)
      cnt_d = CW'(PULSE_CYC);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sys_rst_n = (cnt_q == '0);

  // R7
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !sys_rst_n);
endmodule

// File: rtl/wdog_revert.sv
module wdog_revert
  import wdr_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 14318,
  parameter int unsigned SHORT_MS     = 10,
  parameter int unsigned STEP_MS      = 2000,
  parameter int unsigned RST_MS       = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tmo_code,
  input  logic       reload_bit,
  input  logic       recover_sel,
  output logic       alarm,
  output logic       sys_rst_n,
  output logic       revert_sw
);
  localparam int unsigned MAX_MS    = 15 * STEP_MS;
  localparam int unsigned MS_W      = $clog2(MAX_MS + 1);
  localparam int unsigned PULSE_CYC = RST_MS * TICKS_PER_MS;

  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  logic       ms_tick, running, restart, expire;
  logic       alarm_q, alarm_d, revert_q, revert_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  wdr_ms_tick #(.TICKS_PER_MS(TICKS_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .clr(restart), .run(running), .ms_tick(ms_tick));

  wdr_countdown #(.SHORT_MS(SHORT_MS), .STEP_MS(STEP_MS), .MS_W(MS_W)) u_count (
    .clk(clk), .rst_n(rst_i_n), .code(tmo_code), .reload_bit(reload_bit),
    .ms_tick(ms_tick), .running(running), .restart(restart), .expire(expire));

  wdr_rst_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_i_n), .fire(expire), .sys_rst_n(sys_rst_n));

  always_comb begin
    alarm_d  = alarm_q;
    revert_d = revert_q;
    if (tmo_code == TMO_OFF) alarm_d = 1'b0;
    else if (expire)         alarm_d = 1'b1;
    if (expire)              revert_d = recover_sel;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      alarm_q  <= 1'b0;
      revert_q <= 1'b0;
    end else begin
      alarm_q  <= alarm_d;
      revert_q <= revert_d;
    end
  end

  assign alarm     = alarm_q;
  assign revert_sw = revert_q;

  // R6
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (tmo_code == TMO_OFF) |=> !alarm);
  // R7
  alarm_with_reset_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(alarm) |-> !sys_rst_n);
  // R8
  revert_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !expire |=> $stable(revert_sw));
endmodule

// File: tb/wdog_revert_tb.sv
module wdog_revert_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 2;
  localparam int PULSE      = 3 * T;

  typedef struct { longint cyc; bit sw; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] tmo_code = 4'd0;
  logic reload_bit = 1'b0, recover_sel = 1'b0;
  logic alarm, sys_rst_n, revert_sw;

  exp_t   exp_q[$];
  longint cyc = 0;
  int     nvec = 0, nbad = 0;
  bit     live = 1'b0, done = 1'b0;
  bit     alarm_d = 1'b0, rst_d = 1'b1;
  int     low_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_revert #(.TICKS_PER_MS(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmo_code(tmo_code), .reload_bit(reload_bit),
    .recover_sel(recover_sel), .alarm(alarm), .sys_rst_n(sys_rst_n), .revert_sw(revert_sw));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
  endtask

  // drive at a negedge; the start is sampled at the next posedge; return cyc after it
  task automatic apply(input logic [3:0] c, input logic rl, output longint s);
    @(negedge clk);
    tmo_code = c; reload_bit = rl;
    @(negedge clk);
    s = cyc;
  endtask

  function automatic longint ms_of(input int c);
    return (c == 1) ? 10 : 2000 * c;
  endfunction

  // monitor: pops expectations as alarms rise, measures reset pulses
  always @(negedge clk) begin
    if (live) begin
      if (alarm && !alarm_d) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected alarm", cyc, -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.cyc, "R2/R3/R4/R5 expiry cycle", cyc, e.cyc);
          chk(revert_sw == e.sw, "R8 revert_sw at expiry", revert_sw, e.sw);
          chk(!sys_rst_n, "R7 reset low with alarm", sys_rst_n, 0);
        end
      end else if (!sys_rst_n && rst_d) begin
        chk(1'b0, "R10 reset pulse without alarm edge", cyc, -1);
      end
      if (!sys_rst_n) low_cnt++;
      else if (low_cnt != 0) begin
        chk(low_cnt == PULSE, "R7 reset pulse width", low_cnt, PULSE);
        low_cnt = 0;
      end
    end
    alarm_d = alarm;
    rst_d   = sys_rst_n;
  end

  task automatic settle_expiry();
    wait (exp_q.size() == 0);
    repeat (PULSE + 4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    longint s;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(alarm == 0, "R9 alarm in reset", alarm, 0);
    chk(sys_rst_n == 1, "R9 sys_rst_n in reset", sys_rst_n, 1);
    chk(revert_sw == 0, "R9 revert_sw in reset", revert_sw, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // R1 code 0: nothing happens
    repeat (100) @(negedge clk);
    chk(alarm == 0 && sys_rst_n == 1, "R1 idle with code 0", alarm, 0);

    // R2 short code, keep software setting
    recover_sel = 1'b1;
    apply(4'd1, 1'b0, s);
    exp_q.push_back('{s + ms_of(1) * T, 1'b1});
    settle_expiry();
    recover_sel = 1'b0;                       // R8 must not follow
    repeat (60) @(negedge clk);               // R10 no second pulse in window
    chk(alarm == 1, "R6 alarm sticky", alarm, 1);
    chk(revert_sw == 1, "R8 revert_sw held", revert_sw, 1);
    chk(sys_rst_n == 1, "R10 counter halted", sys_rst_n, 1);
    apply(4'd0, 1'b0, s);
    chk(alarm == 0, "R6 alarm cleared by code 0", alarm, 0);

    // R4 reload edge restarts, held level does not
    apply(4'd1, 1'b0, s);
    repeat (12) @(negedge clk);
    apply(4'd1, 1'b1, s);
    exp_q.push_back('{s + ms_of(1) * T, 1'b0});
    settle_expiry();
    chk(revert_sw == 0, "R8 hardware straps chosen", revert_sw, 0);
    apply(4'd0, 1'b0, s);

    // R5 code change mid-count restarts with new length (R3 code 3)
    recover_sel = 1'b1;
    apply(4'd2, 1'b0, s);
    repeat (3000) @(negedge clk);
    chk(alarm == 0, "R5 no alarm before change", alarm, 0);
    apply(4'd3, 1'b0, s);
    exp_q.push_back('{s + ms_of(3) * T, 1'b1});
    settle_expiry();
    apply(4'd0, 1'b0, s);

    // R3 longest code
    recover_sel = 1'b0;
    apply(4'd15, 1'b0, s);
    exp_q.push_back('{s + ms_of(15) * T, 1'b0});
    settle_expiry();
    apply(4'd0, 1'b0, s);

    // R1 reload edge with code 0 has no effect
    apply(4'd0, 1'b1, s);
    repeat (100) @(negedge clk);
    chk(alarm == 0 && sys_rst_n == 1, "R1 reload ignored when off", alarm, 0);

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule